// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division over many clock cycles and leaves its answer in a pair of result registers, HI and LO. A one-cycle `start` pulse launches the operation and captures the operation code and both operands. The unit then works one bit per cycle: shift-and-add for a product, and shift with a trial subtraction for a quotient. A final cycle applies the sign correction. While it works, `busy` is high.

A product fills both registers, with the upper word in HI and the lower word in LO. A division puts the remainder in HI and the quotient in LO. The two read ports show the register contents at all times, so a processor can move either word out after `busy` drops. The unit raises no fault for an overflowing quotient or a zero divisor. Each of these cases leaves a defined result.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy` low and both `hi_out` and `lo_out` at zero.
- R2: A `start` seen at an edge while idle raises `busy` for exactly WIDTH+1 cycles. These are WIDTH bit iterations and one fix-up cycle. HI and LO take the result at the same edge where `busy` falls.
- R3: With `op` = 2'b01 (unsigned multiply), {HI,LO} equals the unsigned 2·WIDTH-bit product of `src_a` and `src_b`.
- R4: With `op` = 2'b00 (signed multiply), {HI,LO} equals the two's-complement 2·WIDTH-bit product of the signed operands.
- R5: With `op` = 2'b11 (unsigned divide) and a nonzero divisor, LO holds the unsigned quotient and HI holds the remainder.
- R6: With `op` = 2'b10 (signed divide) and a nonzero divisor, the quotient is truncated toward zero and the remainder has the sign of the dividend. The most negative value divided by −1 wraps silently: the quotient is the most negative value and the remainder is 0.
- R7: A zero divisor, with either divide code, gives LO all ones and HI equal to `src_a` as given.
- R8: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands, its result and its WIDTH+1 cycle length.
- R9: HI and LO keep their values at every edge except the edge that completes an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only while idle |
| op | input | 2 | Bit 1: divide when set. Bit 0: unsigned when set |
| src_a | input | WIDTH | Multiplicand or dividend |
| src_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| hi_out | output | WIDTH | HI register: upper product word or remainder |
| lo_out | output | WIDTH | LO register: lower product word or quotient |

## Verification
The bench builds the unit with WIDTH = 4. At that width every operand pair, including every zero divisor, is reachable for all four operation codes. That brings the corners within reach in a few thousand cycles: the most negative value times itself, the most negative value divided by −1, and a negative dividend with a positive divisor. Every launch also has its busy length and HI/LO hold behaviour measured. Extra runs pulse `start` in the middle of an operation, with different operands, to show that the pulse has no effect.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Bit 1 selects divide, bit 0 selects unsigned arithmetic.
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_FIX  = 2'b10
    } mdu_state_e;

    typedef struct packed {
        logic load;    // capture operands
        logic step;    // one bit iteration
        logic finish;  // write HI/LO
    } mdu_ctl_t;

    function automatic logic op_is_div(input mdu_op_e o);
        return o[1];
    endfunction

    function automatic logic op_is_signed(input mdu_op_e o);
        return !o[0];
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     busy,
    output mdu_ctl_t ctl
);
    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mdu_state_e      state_q;
    logic [CW-1:0]   iter_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_ITER;
                    iter_q  <= '0;
                end
                ST_ITER: begin
                    iter_q <= iter_q + 1'b1;
                    if (iter_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load   = (state_q == ST_IDLE) && start;
        ctl.step   = (state_q == ST_ITER);
        ctl.finish = (state_q == ST_FIX);
        busy       = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/mdu_core.sv
module mdu_core
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  mdu_ctl_t         ctl,
    input  mdu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] hi_res,
    output logic [WIDTH-1:0] lo_res
);
    localparam int DW = 2 * WIDTH;

    logic             div_q, neg_res_q, neg_rem_q, zero_q;
    logic [WIDTH:0]   upper_q;     // accumulator or partial remainder
    logic [WIDTH-1:0] lower_q;     // multiplier or dividend -> quotient
    logic [WIDTH-1:0] operand_q;   // multiplicand or divisor magnitude

    logic             sa, sb, sgn;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH:0]   add_sum, shifted, trial;
    logic [DW-1:0]    prod;
    logic [WIDTH-1:0] quo, rem;

    always_comb begin
        sgn   = op_is_signed(op);
        sa    = sgn && a[WIDTH-1];
        sb    = sgn && b[WIDTH-1];
        mag_a = sa ? (~a + 1'b1) : a;
        mag_b = sb ? (~b + 1'b1) : b;

        add_sum = {1'b0, upper_q[WIDTH-1:0]} + (lower_q[0] ? {1'b0, operand_q} : '0);
        shifted = {upper_q[WIDTH-1:0], lower_q[WIDTH-1]};
        trial   = shifted - {1'b0, operand_q};
    end

    always_ff @(posedge clk) begin
        if (ctl.load) begin
            div_q     <= op_is_div(op);
            neg_res_q <= sa ^ sb;
            neg_rem_q <= sa;
            zero_q    <= (b == '0);
            upper_q   <= '0;
            lower_q   <= op_is_div(op) ? mag_a : mag_b;
            operand_q <= op_is_div(op) ? mag_b : mag_a;
        end else if (ctl.step) begin
            if (div_q) begin
                if (!trial[WIDTH]) begin
                    upper_q <= trial;
                    lower_q <= {lower_q[WIDTH-2:0], 1'b1};
                end else begin
                    upper_q <= shifted;
                    lower_q <= {lower_q[WIDTH-2:0], 1'b0};
                end
            end else begin
                upper_q <= {1'b0, add_sum[WIDTH:1]};
                lower_q <= {add_sum[0], lower_q[WIDTH-1:1]};
            end
        end
    end

    // Sign fix-up on the magnitudes produced by the iterations.
    always_comb begin
        prod = {upper_q[WIDTH-1:0], lower_q};
        if (neg_res_q) prod = ~prod + 1'b1;
        quo = lower_q;
        if (zero_q)         quo = '1;
        else if (neg_res_q) quo = ~lower_q + 1'b1;
        rem = neg_rem_q ? (~upper_q[WIDTH-1:0] + 1'b1) : upper_q[WIDTH-1:0];
        hi_res = div_q ? rem : prod[DW-1:WIDTH];
        lo_res = div_q ? quo : prod[WIDTH-1:0];
    end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [WIDTH-1:0] hi_in,
    input  logic [WIDTH-1:0] lo_in,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr) begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic             busy,
    output logic [WIDTH-1:0] hi_out,
    output logic [WIDTH-1:0] lo_out
);
    mdu_ctl_t         ctl;
    logic [WIDTH-1:0] hi_res, lo_res;

    mdu_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .ctl   (ctl)
    );

    mdu_core #(.WIDTH(WIDTH)) core_i (
        .clk    (clk),
        .ctl    (ctl),
        .op     (mdu_op_e'(op)),
        .a      (src_a),
        .b      (src_b),
        .hi_res (hi_res),
        .lo_res (lo_res)
    );

    mdu_hilo #(.WIDTH(WIDTH)) hilo_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl.finish),
        .hi_in (hi_res),
        .lo_in (lo_res),
        .hi_q  (hi_out),
        .lo_q  (lo_out)
    );

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);
    localparam int CW = $clog2(WIDTH + 2) + 1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && hi == '0 && lo == '0));

    // R2
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_cnt == CW'(WIDTH + 1));

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_cnt <= CW'(WIDTH));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy && run_cnt < CW'(WIDTH)) |=> busy);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> ($stable(hi) && $stable(lo)));

endmodule

bind muldiv_unit mdu_checker #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .hi    (hi_out),
    .lo    (lo_out)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MASKW = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   op;
    logic [W-1:0] src_a, src_b;
    logic         busy;
    logic [W-1:0] hi_out, lo_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .busy(busy), .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= (1 << (W-1))) ? v - (1 << W) : v;
    endfunction

    // Expected {hi,lo} from the requirements: op bit1 = divide, bit0 = unsigned.
    function automatic void model(input int o, input int a, input int b,
                                  output int eh, output int el);
        int p, q, r;
        if (o[1] == 1'b0) begin
            p  = (o[0] ? a * b : sx(a) * sx(b)) & ((1 << (2*W)) - 1);
            eh = (p >> W) & MASKW;
            el = p & MASKW;
        end else if (b == 0) begin
            eh = a;
            el = MASKW;
        end else begin
            if (o[0]) begin q = a / b; r = a % b; end
            else      begin q = sx(a) / sx(b); r = sx(a) % sx(b); end
            eh = r & MASKW;
            el = q & MASKW;
        end
    endfunction

    function automatic string req_of(input int o, input int b);
        if (o[1] && b == 0) return "R7";
        case (o)
            0: return "R4";
            1: return "R3";
            2: return "R6";
            default: return "R5";
        endcase
    endfunction

    // intr_at > 0: pulse start with other operands at that busy sample (R8).
    task automatic run_op(input int o, input int a, input int b, input int intr_at);
        int n, eh, el, old_hi, old_lo;
        old_hi = hi_out;
        old_lo = lo_out;
        @(negedge clk);
        start = 1'b1; op = 2'(o); src_a = W'(a); src_b = W'(b);
        @(negedge clk);
        start = 1'b0;
        src_a = W'(a + 5); src_b = W'(b + 3); op = 2'(o ^ 1);
        check("R9 hi held during run", hi_out, old_hi);
        check("R9 lo held during run", lo_out, old_lo);
        n = 0;
        while (busy && n < 4*W) begin
            n++;
            if (intr_at > 0 && n == intr_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        model(o, a, b, eh, el);
        check(intr_at > 0 ? "R8 busy length" : "R2 busy length", n, W + 1);
        check({intr_at > 0 ? "R8 " : "", req_of(o, b), " hi"}, hi_out, eh);
        check({intr_at > 0 ? "R8 " : "", req_of(o, b), " lo"}, lo_out, el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int h0, l0;
        rst = 1'b1; start = 1'b0; op = 2'b00; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 hi", hi_out, 0);
        check("R1 lo", lo_out, 0);
        rst = 1'b0;

        // Exhaustive sweep: R3 R4 R5 R6 R7 with R2 R9 on every run
        for (int o = 0; o < 4; o++)
            for (int a = 0; a <= MASKW; a++)
                for (int b = 0; b <= MASKW; b++)
                    run_op(o, a, b, 0);

        // R6 corner: most negative / -1 wraps quietly
        run_op(2, 1 << (W-1), MASKW, 0);
        check("R6 wrap quotient", lo_out, 1 << (W-1));
        check("R6 wrap remainder", hi_out, 0);

        // R8: start pulses mid-run are ignored
        run_op(0, 5, MASKW - 2, 2);
        run_op(3, 13, 3, W);
        run_op(2, 9, 0, 1);

        // R9: outputs hold while idle
        h0 = hi_out; l0 = lo_out;
        src_a = W'(7); src_b = W'(2);
        repeat (5) @(negedge clk);
        check("R9 hi idle hold", hi_out, h0);
        check("R9 lo idle hold", lo_out, l0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule